// File: doc/BRIEF.md
# Level Interrupt Combiner

This block gathers up to sixteen level-sensitive interrupt sources from a board control device and merges them into a single level line for a host interrupt input. Each source has a status bit that captures a request, an enable bit that controls capture, and a mask bit. A source reaches the combined line only while its enable and its mask are both set. Enable and mask can only be changed through dedicated set and clear registers, where each written 1 acts on one bit. Because of this, software never needs a read-modify-write sequence to change a single source.

The host reaches the block through a small register port with 16-bit data. Registers sit on 4-byte boundaries. Writing ones to the status register acknowledges those sources. A source that is still requesting, and still enabled, captures again on the next clock. An interrupt service routine reads status, handles the pending bits starting from the lowest index, and acknowledges each one.

Top module: `lvl_irq_combiner`

## Requirements
- R1: After synchronous reset, the status, enable and mask registers are all zero, `irq_out` is low and `bus_rdata` is zero.
- R2: A write to byte offset 0x04 sets every enable bit written as 1. A write to offset 0x08 clears every enable bit written as 1. Bits written as 0 keep their value. Reads of either offset return the enable vector, and enable writes leave the mask unchanged.
- R3: Offsets 0x0C and 0x10 do the same for the mask vector: 0x0C sets and 0x10 clears, with the same write-one rule. Reads of either offset return the mask vector, and mask writes leave the enable vector unchanged.
- R4: Status bit i becomes 1 on the clock after `src_lvl[i]` is high while enable bit i is set. It stays 0 while enable bit i is clear. The mask has no effect on capture. Reads of offset 0x00 return status, with bit i matching source i.
- R5: Writing a 1 to bit i at offset 0x00 clears status bit i, and bits written as 0 are unaffected. If the source is high and enabled in the same clock as the acknowledge, the set wins and the bit stays 1.
- R6: `irq_out` is high on the clock after any source has status, enable and mask all set, and low on the clock after none has. Clearing only the enable or only the mask silences that source with no further pulse.
- R7: Writes to any offset other than the five word offsets above are ignored. This includes addresses that are not 4-byte aligned. Reads of such offsets return zero.
- R8: Writing 0xFFFF to the enable-clear, mask-clear and status offsets leaves every source disabled, masked and acknowledged, and `irq_out` low.
- R9: `bus_rdata` carries the addressed register on the clock after `bus_rd` is high, and is zero on any clock that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_lvl | input | 16 | Level interrupt requests, one per source |
| irq_out | output | 1 | Combined registered interrupt line |

## Verification
The hardest case to produce from the ports is an acknowledge write that lands in the same clock as a fresh rise of the same source. Outside the bench this depends on chance timing between software and hardware. The bench first lets the source drop with its status still held. It then changes the source and raises the write strobe on the same falling edge, so that both are sampled together. A control acknowledge with the source low shows the bit really clears when nothing competes with it. A sweep over every source and all four enable and mask combinations covers the gating.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_MSK_SET,
    SEL_MSK_CLR,
    SEL_NONE
  } reg_sel_e;

  // Word indices (byte offset / 4) of the live registers
  localparam logic [31:0] WIDX_STATUS  = 32'd0;
  localparam logic [31:0] WIDX_EN_SET  = 32'd1;
  localparam logic [31:0] WIDX_EN_CLR  = 32'd2;
  localparam logic [31:0] WIDX_MSK_SET = 32'd3;
  localparam logic [31:0] WIDX_MSK_CLR = 32'd4;

  // Misaligned byte lanes decode to no register.
  function automatic reg_sel_e decode_sel(input logic [1:0] lane, input logic [31:0] widx);
    reg_sel_e s;
    s = SEL_NONE;
    if (lane == 2'b00) begin
      case (widx)
        WIDX_STATUS:  s = SEL_STATUS;
        WIDX_EN_SET:  s = SEL_EN_SET;
        WIDX_EN_CLR:  s = SEL_EN_CLR;
        WIDX_MSK_SET: s = SEL_MSK_SET;
        WIDX_MSK_CLR: s = SEL_MSK_CLR;
        default:      s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/lvl_irq_setclr.sv
// Bit vector changed only by write-one-to-set and write-one-to-clear strobes.
module lvl_irq_setclr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);

  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  assign set_v = set_stb ? bits : '0;
  assign clr_v = clr_stb ? bits : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set_v;
  end

  // R2 / R3: without a strobe the vector must not move
  p_q_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(set_stb || clr_stb) |=> $stable(q));

  // R3: a set strobe never drops a bit, a clear strobe never raises one
  p_set_no_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (set_stb && !clr_stb) |=> ((q & $past(q)) == $past(q)));
  p_clr_no_raise_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((q & ~$past(q)) == '0));

endmodule

// File: rtl/lvl_irq_regfile.sv
// Host port decode, enable/mask storage, acknowledge vector and read mux.
module lvl_irq_regfile
  import lvl_irq_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int DW     = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [NSRC-1:0]   stat_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   mask_q,
  output logic [NSRC-1:0]   ack_vec,
  output logic [DW-1:0]     bus_rdata
);

  localparam int WIDX_W = ADDR_W - 2;

  reg_sel_e          sel;
  logic [NSRC-1:0]   wbits;
  logic [WIDX_W-1:0] widx;

  assign widx  = bus_addr[ADDR_W-1:2];
  assign sel   = decode_sel(bus_addr[1:0], 32'(widx));
  assign wbits = bus_wdata[NSRC-1:0];

  lvl_irq_setclr #(.W(NSRC)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .set_stb (bus_wr && (sel == SEL_EN_SET)),
    .clr_stb (bus_wr && (sel == SEL_EN_CLR)),
    .bits    (wbits),
    .q       (en_q)
  );

  lvl_irq_setclr #(.W(NSRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .set_stb (bus_wr && (sel == SEL_MSK_SET)),
    .clr_stb (bus_wr && (sel == SEL_MSK_CLR)),
    .bits    (wbits),
    .q       (mask_q)
  );

  assign ack_vec = (bus_wr && (sel == SEL_STATUS)) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        SEL_STATUS:                 bus_rdata <= DW'(stat_q);
        SEL_EN_SET,  SEL_EN_CLR:    bus_rdata <= DW'(en_q);
        SEL_MSK_SET, SEL_MSK_CLR:   bus_rdata <= DW'(mask_q);
        default:                    bus_rdata <= '0;
      endcase
    end
  end

  // R9: no read strobe, no data
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R7: writes to unused offsets change no gate
  p_unused_write_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (sel == SEL_NONE)) |=> ($stable(en_q) && $stable(mask_q)));

  // R7: unused offsets read as zero
  p_unused_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel == SEL_NONE)) |=> (bus_rdata == '0));

endmodule

// File: rtl/lvl_irq_status.sv
// Per-source pending capture with write-one acknowledge; capture wins a tie.
module lvl_irq_status #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] ack_vec,
  output logic [NSRC-1:0] stat_q
);

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                      stat_q[g] <= 1'b0;
      else if (src_lvl[g] && en_q[g]) stat_q[g] <= 1'b1;
      else if (ack_vec[g])          stat_q[g] <= 1'b0;
    end
  end

  // R4: a bit only rises after an enabled request
  p_rise_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_lvl & en_q)) == '0));

  // R5: a bit only falls after an acknowledge
  p_fall_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(ack_vec)) == '0));

  // R5: an enabled request is never lost to a concurrent acknowledge
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(src_lvl & en_q) & ~stat_q) == '0));

endmodule

// File: rtl/lvl_irq_merge.sv
// Two-gate qualification of pending bits and registered OR to one line.
module lvl_irq_merge #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] stat_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] mask_q,
  output logic            irq_q
);

  logic [NSRC-1:0] live;

  assign live = stat_q & en_q & mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |live;
  end

  // R6: a qualified source raises the line one clock later
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (|live) |=> irq_q);

  // R6: with no qualified source the line drops one clock later
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(|live) |=> !irq_q);

endmodule

// File: rtl/lvl_irq_combiner.sv
module lvl_irq_combiner #(
  parameter int NSRC   = 16,
  parameter int DW     = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              irq_out
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] ack_vec;

  lvl_irq_regfile #(.NSRC(NSRC), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .ack_vec   (ack_vec),
    .bus_rdata (bus_rdata)
  );

  lvl_irq_status #(.NSRC(NSRC)) u_status (
    .clk     (clk),
    .rst     (rst),
    .src_lvl (src_lvl),
    .en_q    (en_q),
    .ack_vec (ack_vec),
    .stat_q  (stat_q)
  );

  lvl_irq_merge #(.NSRC(NSRC)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .stat_q (stat_q),
    .en_q   (en_q),
    .mask_q (mask_q),
    .irq_q  (irq_out)
  );

  // R8 / R1: line cannot be high while every enable is clear
  p_no_irq_all_off_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_out);

endmodule

// File: tb/lvl_irq_combiner_bench.sv
`timescale 1ns/1ps
module lvl_irq_combiner_bench;

  localparam logic [7:0] A_ST  = 8'h00;
  localparam logic [7:0] A_ENS = 8'h04;
  localparam logic [7:0] A_ENC = 8'h08;
  localparam logic [7:0] A_MS  = 8'h0C;
  localparam logic [7:0] A_MC  = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] src_lvl = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lvl_irq_combiner u_lvl_irq_combiner (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_lvl   (src_lvl),
    .irq_out   (irq_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wipe();
    wr(A_ENC, 16'hFFFF); wr(A_MC, 16'hFFFF); wr(A_ST, 16'hFFFF);
  endtask

  initial begin
    logic [15:0] d;
    logic [15:0] b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 irq", 16'(irq_out), 16'h0);
    chk("R1 rdata", bus_rdata, 16'h0);
    rd(A_ST, d);  chk("R1 status", d, 16'h0);
    rd(A_ENS, d); chk("R1 enable", d, 16'h0);
    rd(A_MC, d);  chk("R1 mask", d, 16'h0);

    // R2: enable set/clear
    wr(A_ENS, 16'h00F0); rd(A_ENS, d); chk("R2 set", d, 16'h00F0);
    wr(A_ENS, 16'h0003); rd(A_ENC, d); chk("R2 accumulate", d, 16'h00F3);
    wr(A_ENC, 16'h0030); rd(A_ENS, d); chk("R2 clear", d, 16'h00C3);
    wr(A_ENC, 16'h0000); rd(A_ENC, d); chk("R2 zero write", d, 16'h00C3);
    rd(A_MS, d); chk("R2 mask untouched", d, 16'h0000);

    // R3: mask set/clear
    wr(A_MS, 16'hA500); rd(A_MS, d); chk("R3 set", d, 16'hA500);
    wr(A_MS, 16'h0081); wr(A_MC, 16'h2400); rd(A_MC, d); chk("R3 clear", d, 16'h8181);
    rd(A_ENS, d); chk("R3 enable untouched", d, 16'h00C3);

    // R9: data only after a read strobe
    idle(1);
    chk("R9 idle rdata", bus_rdata, 16'h0);

    // R4 / R5 / R6: sweep every source over all gate combinations
    for (int i = 0; i < 16; i++) begin
      for (int c = 0; c < 4; c++) begin
        wipe();
        b = 16'h1 << i;
        if (c[0]) wr(A_ENS, b);
        if (c[1]) wr(A_MS, b);
        src_lvl = b;
        idle(3);
        rd(A_ST, d);
        chk("R4 capture", d, c[0] ? b : 16'h0);
        chk("R6 gating", 16'(irq_out), (c == 3) ? 16'h1 : 16'h0);
        src_lvl = '0;
        wr(A_ST, b);
        idle(2);
        rd(A_ST, d);
        chk("R5 ack", d, 16'h0);
        chk("R6 after ack", 16'(irq_out), 16'h0);
      end
    end

    // R6: clearing one gate silences with no extra pulse
    wipe();
    wr(A_ENS, 16'h0080); wr(A_MS, 16'h0080);
    src_lvl = 16'h0080;
    idle(3);
    chk("R6 raised", 16'(irq_out), 16'h1);
    wr(A_MC, 16'h0080);
    for (int k = 0; k < 4; k++) begin
      idle(1);
      chk("R6 mask silences", 16'(irq_out), 16'h0);
    end
    rd(A_ST, d); chk("R6 status kept", d, 16'h0080);
    wr(A_MS, 16'h0080);
    idle(2);
    chk("R6 unmask", 16'(irq_out), 16'h1);
    wr(A_ENC, 16'h0080);
    for (int k = 0; k < 4; k++) begin
      idle(1);
      chk("R6 enable silences", 16'(irq_out), 16'h0);
    end
    src_lvl = '0;

    // R5: partial acknowledge
    wipe();
    wr(A_ENS, 16'h0005);
    src_lvl = 16'h0005; idle(2); src_lvl = '0;
    wr(A_ST, 16'h0001);
    rd(A_ST, d); chk("R5 partial ack", d, 16'h0004);

    // R5: capture and acknowledge in the same clock
    wr(A_ENS, 16'h0008);
    src_lvl = 16'h0008; idle(2); src_lvl = '0; idle(1);
    src_lvl = 16'h0008;
    wr(A_ST, 16'h0008);
    src_lvl = '0;
    rd(A_ST, d); chk("R5 set wins", d, 16'h000C);
    wr(A_ST, 16'h0008);
    rd(A_ST, d); chk("R5 plain ack", d, 16'h0004);

    // R5: source held high re-captures after acknowledge
    src_lvl = 16'h0004;
    wr(A_ST, 16'h0004);
    idle(1);
    rd(A_ST, d); chk("R5 recapture", d, 16'h0004);
    src_lvl = '0;

    // R7: unused and misaligned offsets
    wipe();
    wr(A_ENS, 16'h1234); wr(A_MS, 16'h00FF);
    src_lvl = 16'h0010; idle(2); src_lvl = '0;
    wr(8'h14, 16'hFFFF); wr(8'h18, 16'hFFFF); wr(8'hFC, 16'hFFFF);
    wr(8'h05, 16'hFFFF); wr(8'h0A, 16'hFFFF); wr(8'h01, 16'hFFFF);
    rd(A_ENS, d); chk("R7 enable kept", d, 16'h1234);
    rd(A_MS, d);  chk("R7 mask kept", d, 16'h00FF);
    rd(A_ST, d);  chk("R7 status kept", d, 16'h0010);
    rd(8'h14, d); chk("R7 read unused", d, 16'h0);
    rd(8'h06, d); chk("R7 read misaligned", d, 16'h0);

    // R8: bulk disable, mask and acknowledge
    wr(A_ENS, 16'hFFFF); wr(A_MS, 16'hFFFF);
    src_lvl = 16'hFFFF; idle(3);
    chk("R8 all live", 16'(irq_out), 16'h1);
    src_lvl = '0;
    wipe();
    idle(2);
    rd(A_ST, d);  chk("R8 status", d, 16'h0);
    rd(A_ENC, d); chk("R8 enable", d, 16'h0);
    rd(A_MC, d);  chk("R8 mask", d, 16'h0);
    chk("R8 irq", 16'(irq_out), 16'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule